// File: doc/BRIEF.md
# Shift-Register Host Handshake Engine

This block carries bytes between a host processor and a peripheral controller through one byte-wide shift-register value and three active-low handshake lines. The host owns two of the lines: a transfer-active strobe and a transfer-acknowledge strobe. It also owns a direction bit. The block drives the third line, a device-request strobe. No shift clock is involved. A byte moves whenever the registered copy of the host's two strobes differs from their present value. In the host-to-device direction the byte the host wrote is appended to an outgoing packet buffer. In the device-to-host direction the next byte of a pending reply is placed on the byte the host reads.

Every byte movement, every end of a transfer and every resynchronisation schedules a shift-register interrupt. The interrupt is raised a fixed number of clock cycles later. Scheduling it again before it is raised pushes it back to a full delay. When the host ends a transfer that carried at least one byte toward the device, the block emits a one-cycle packet strobe with the byte count. Downstream logic reads the packet bytes by index. Downstream logic also supplies replies: it writes bytes into a reply buffer and then starts the reply with its length.

Top module: `shreg_handshake`

## Requirements
- R1: After reset dev_req_n is 1, sr_irq is 0, pkt_valid is 0 and dev_byte is 0x00.
- R2: With xfer_act_n low and dir_to_dev 1, every clock edge where {xfer_act_n, xfer_ack_n} differs from the value sampled at the previous edge stores host_byte at the next outgoing index, starting from index 0. An unchanged pair stores nothing.
- R3: The outgoing buffer holds 16 bytes. Further bytes in the same packet are dropped, and the packet length stops at 16.
- R4: With xfer_act_n low, dir_to_dev 0 and reply bytes remaining, every pair change loads the next reply byte onto dev_byte one cycle after the sampling edge.
- R5: dev_req_n goes to 1 in the same cycle that the last reply byte appears on dev_byte.
- R6: On the edge that samples xfer_act_n rising (previous sample 0, present sample 1), pkt_valid pulses for one cycle with pkt_len equal to the number of bytes captured, but only if that number is nonzero. The outgoing index then restarts at 0.
- R7: On that same rising edge, dev_req_n goes to 0 if reply bytes remain and otherwise keeps its value.
- R8: While xfer_act_n is sampled 1 on two consecutive edges and xfer_ack_n changes between them, dev_req_n becomes 0 if reply bytes remain and 1 otherwise.
- R9: sr_irq is a one-cycle pulse exactly IRQ_DELAY cycles after the most recent scheduling edge. Any scheduling event (R2, R4, R6, R8, R10) that comes earlier restarts the delay.
- R10: A pulse on rsp_start sets the reply length to rsp_len, restarts the reply read index at 0 and schedules an interrupt. It does not change dev_req_n.
- R11: With dir_to_dev 0 and no reply bytes remaining, a pair change leaves dev_byte unchanged and schedules no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_act_n | input | 1 | Host transfer-active strobe, active low |
| xfer_ack_n | input | 1 | Host acknowledge strobe, active low |
| dir_to_dev | input | 1 | 1 = host-to-device, 0 = device-to-host |
| host_byte | input | 8 | Byte the host wrote into the shift register |
| dev_byte | output | 8 | Byte presented to the host |
| dev_req_n | output | 1 | Device request strobe, active low |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |
| rsp_we | input | 1 | Reply buffer write enable |
| rsp_waddr | input | 4 | Reply buffer write index |
| rsp_wdata | input | 8 | Reply buffer write byte |
| rsp_start | input | 1 | Start a new reply |
| rsp_len | input | 5 | Reply length in bytes, 0 to 16 |
| pkt_valid | output | 1 | One-cycle completed-packet strobe |
| pkt_len | output | 5 | Byte count of the completed packet |
| pkt_sel | input | 4 | Outgoing buffer read index |
| pkt_byte | output | 8 | Outgoing buffer byte at pkt_sel |

## Verification
dev_byte, dev_req_n, pkt_valid and pkt_len change one cycle after the edge that samples the stimulus. sr_irq comes IRQ_DELAY cycles after the last scheduling edge. pkt_byte follows pkt_sel with no clock. The driver records the number of the edge that will sample each stimulus and queues every expected output event with that edge number. The monitor samples 1 ns after each rising edge and matches each change against the head of the queue, including its cycle. It checks sr_irq on every cycle against the single expected pulse cycle, so a pulse that is early, late or missing is caught.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;
    localparam int BUF_DEPTH = 16;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(BUF_DEPTH);
    localparam int CNT_W     = $clog2(BUF_DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  out_cnt;
        logic [CNT_W-1:0]  rd_idx;
        logic [CNT_W-1:0]  rsp_len;
        logic [BYTE_W-1:0] sr_rd;
        logic              treq_n;
        logic              pkt_valid;
        logic [CNT_W-1:0]  pkt_len;
        logic              prev_act_n;
        logic              prev_ack_n;
    } hs_state_t;
endpackage

// File: rtl/shreg_bytebuf.sv
`timescale 1ns/1ps
module shreg_bytebuf #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(i)) begin
                cell_q[i] <= wdata;
            end
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/shreg_irq_timer.sv
`timescale 1ns/1ps
module shreg_irq_timer #(
    parameter int DELAY = 4000,
    localparam int TW   = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sched,
    output logic irq
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          irq;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.irq = 1'b0;
        if (sched) begin
            t_d.cnt = TW'(DELAY);
        end else if (t_q.cnt == TW'(1)) begin
            t_d.cnt = '0;
            t_d.irq = 1'b1;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign irq = t_q.irq;

    AST_IRQ_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.irq |-> ($past(t_q.cnt) == TW'(1) && !$past(sched))); // R9
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.irq |=> !t_q.irq || $past(sched) == 1'b0); // R9
endmodule

// File: rtl/shreg_handshake.sv
`timescale 1ns/1ps
module shreg_handshake
    import shreg_pkg::*;
#(
    parameter int IRQ_DELAY = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_act_n,
    input  logic              xfer_ack_n,
    input  logic              dir_to_dev,
    input  logic [BYTE_W-1:0] host_byte,
    output logic [BYTE_W-1:0] dev_byte,
    output logic              dev_req_n,
    output logic              sr_irq,
    input  logic              rsp_we,
    input  logic [IDX_W-1:0]  rsp_waddr,
    input  logic [BYTE_W-1:0] rsp_wdata,
    input  logic              rsp_start,
    input  logic [CNT_W-1:0]  rsp_len,
    output logic              pkt_valid,
    output logic [CNT_W-1:0]  pkt_len,
    input  logic [IDX_W-1:0]  pkt_sel,
    output logic [BYTE_W-1:0] pkt_byte
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(BUF_DEPTH);

    hs_state_t         s_d, s_q;
    logic              sched;
    logic              out_we;
    logic              pair_chg;
    logic              pending;
    logic [CNT_W-1:0]  rd_next;
    logic [BYTE_W-1:0] rsp_rdata;

    shreg_bytebuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_out_buf (
        .clk   (clk),
        .we    (out_we),
        .waddr (s_q.out_cnt[IDX_W-1:0]),
        .wdata (host_byte),
        .raddr (pkt_sel),
        .rdata (pkt_byte)
    );

    shreg_bytebuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_rsp_buf (
        .clk   (clk),
        .we    (rsp_we),
        .waddr (rsp_waddr),
        .wdata (rsp_wdata),
        .raddr (s_q.rd_idx[IDX_W-1:0]),
        .rdata (rsp_rdata)
    );

    shreg_irq_timer #(.DELAY(IRQ_DELAY)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .sched (sched),
        .irq   (sr_irq)
    );

    assign pair_chg = ({xfer_act_n, xfer_ack_n} != {s_q.prev_act_n, s_q.prev_ack_n});
    assign pending  = (s_q.rd_idx < s_q.rsp_len);
    assign rd_next  = s_q.rd_idx + CNT_W'(1);

    always_comb begin
        s_d           = s_q;
        s_d.pkt_valid = 1'b0;
        sched         = 1'b0;
        out_we        = 1'b0;
        if (!xfer_act_n) begin
            if (dir_to_dev) begin
                if (pair_chg && s_q.out_cnt < DEPTH_C) begin
                    out_we      = 1'b1;
                    s_d.out_cnt = s_q.out_cnt + CNT_W'(1);
                    sched       = 1'b1;
                end
            end else if (pending && pair_chg) begin
                s_d.sr_rd  = rsp_rdata;
                s_d.rd_idx = rd_next;
                if (rd_next >= s_q.rsp_len) begin
                    s_d.treq_n = 1'b1;
                end
                sched = 1'b1;
            end
        end else if (s_q.prev_act_n) begin
            if (xfer_ack_n != s_q.prev_ack_n) begin
                s_d.treq_n = !pending;
                sched      = 1'b1;
            end
        end else begin
            sched = 1'b1;
            if (s_q.out_cnt != '0) begin
                s_d.pkt_valid = 1'b1;
                s_d.pkt_len   = s_q.out_cnt;
            end
            s_d.out_cnt = '0;
            if (pending) begin
                s_d.treq_n = 1'b0;
            end
        end
        if (rsp_start) begin
            s_d.rd_idx  = '0;
            s_d.rsp_len = rsp_len;
            sched       = 1'b1;
        end
        s_d.prev_act_n = xfer_act_n;
        s_d.prev_ack_n = xfer_ack_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.treq_n     <= 1'b1;
            s_q.prev_act_n <= 1'b1;
            s_q.prev_ack_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dev_byte  = s_q.sr_rd;
    assign dev_req_n = s_q.treq_n;
    assign pkt_valid = s_q.pkt_valid;
    assign pkt_len   = s_q.pkt_len;

    AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.out_cnt <= DEPTH_C); // R3
    AST_PKT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pkt_valid |-> (s_q.prev_act_n && !$past(s_q.prev_act_n))); // R6
    AST_PKT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pkt_valid |-> (s_q.pkt_len != '0)); // R6
    AST_RD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_idx <= s_q.rsp_len); // R4
    AST_SR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.sr_rd) |-> $past(!xfer_act_n && !dir_to_dev)); // R4
    AST_END_TREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(s_q.sr_rd) && s_q.rd_idx == s_q.rsp_len && !$past(rsp_start))
        |-> s_q.treq_n); // R5
endmodule

// File: tb/shreg_handshake_tb.sv
`timescale 1ns/1ps
module shreg_handshake_tb;
    import shreg_pkg::*;

    localparam int D = 40;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              xfer_act_n, xfer_ack_n, dir_to_dev;
    logic [BYTE_W-1:0] host_byte;
    logic [BYTE_W-1:0] dev_byte;
    logic              dev_req_n, sr_irq;
    logic              rsp_we;
    logic [IDX_W-1:0]  rsp_waddr;
    logic [BYTE_W-1:0] rsp_wdata;
    logic              rsp_start;
    logic [CNT_W-1:0]  rsp_len;
    logic              pkt_valid;
    logic [CNT_W-1:0]  pkt_len;
    logic [IDX_W-1:0]  pkt_sel;
    logic [BYTE_W-1:0] pkt_byte;

    always #2.5 clk = ~clk;

    shreg_handshake #(.IRQ_DELAY(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_act_n(xfer_act_n), .xfer_ack_n(xfer_ack_n),
        .dir_to_dev(dir_to_dev), .host_byte(host_byte), .dev_byte(dev_byte),
        .dev_req_n(dev_req_n), .sr_irq(sr_irq), .rsp_we(rsp_we), .rsp_waddr(rsp_waddr),
        .rsp_wdata(rsp_wdata), .rsp_start(rsp_start), .rsp_len(rsp_len),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_sel(pkt_sel), .pkt_byte(pkt_byte)
    );

    typedef struct {
        int    kind;   // 0 dev_req_n, 1 dev_byte, 2 packet strobe
        int    val;
        int    at;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    cyc = 0;
    int    nedge = 0;
    int    exp_irq = -1;
    int    checks = 0;
    int    errors = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    logic  last_treq = 1'b1;
    logic [7:0] last_sr = 8'h00;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic expect_ev(input int kind, input int val, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.val = val; e.at = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic pop_cmp(input int kind, input int val);
        exp_t e;
        string ktag;
        ktag = (kind == 0) ? "R7" : (kind == 1) ? "R4" : "R6";
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected event kind %0d actual 0x%0h expected none (cycle %0d)",
                     ktag, kind, val, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.val != val || e.at != cyc) begin
                errors++;
                $display("FAIL %s: kind %0d actual 0x%0h at %0d expected kind %0d 0x%0h at %0d",
                         e.tag, kind, val, cyc, e.kind, e.val, e.at);
            end
        end
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (dev_req_n !== last_treq) pop_cmp(0, int'(dev_req_n));
                last_treq = dev_req_n;
                if (dev_byte !== last_sr) pop_cmp(1, int'(dev_byte));
                last_sr = dev_byte;
                if (pkt_valid) pop_cmp(2, int'(pkt_len));
                if (sr_irq || cyc == exp_irq)
                    check(sr_irq == 1'b1 && cyc == exp_irq, "R9",
                          sr_irq ? cyc : -1, exp_irq);
            end
        end
    end

    task automatic drive(input logic act, input logic ack, input logic dir, input logic [7:0] b);
        @(negedge clk);
        rsp_we = 1'b0; rsp_start = 1'b0;
        xfer_act_n = act; xfer_ack_n = ack; dir_to_dev = dir; host_byte = b;
        nedge = cyc + 1;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_irq();
        while (cyc <= exp_irq + 1) @(negedge clk);
    endtask

    task automatic start_reply(input int len);
        @(negedge clk);
        rsp_we = 1'b0;
        rsp_start = 1'b1; rsp_len = CNT_W'(len);
        nedge = cyc + 1;
        exp_irq = nedge + D; // R10 schedules an interrupt
        @(negedge clk);
        rsp_start = 1'b0;
    endtask

    task automatic write_reply(input int idx, input logic [7:0] b);
        @(negedge clk);
        rsp_start = 1'b0;
        rsp_we = 1'b1; rsp_waddr = IDX_W'(idx); rsp_wdata = b;
        @(negedge clk);
        rsp_we = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1: watchdog expired actual 0x0 expected 0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        xfer_act_n = 1'b1; xfer_ack_n = 1'b1; dir_to_dev = 1'b1; host_byte = 8'h00;
        rsp_we = 1'b0; rsp_waddr = '0; rsp_wdata = 8'h00; rsp_start = 1'b0; rsp_len = '0;
        pkt_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        check(dev_req_n == 1'b1, "R1", int'(dev_req_n), 1);
        check(sr_irq == 1'b0, "R1", int'(sr_irq), 0);
        check(pkt_valid == 1'b0, "R1", int'(pkt_valid), 0);
        check(dev_byte == 8'h00, "R1", int'(dev_byte), 0);
        mon_on = 1'b1;

        // Scenario A: three-byte host packet, R2 and R6
        drive(1'b0, 1'b1, 1'b1, 8'hA1); exp_irq = nedge + D;
        drive(1'b0, 1'b0, 1'b1, 8'hB2); exp_irq = nedge + D;
        drive(1'b0, 1'b1, 1'b1, 8'hC3); exp_irq = nedge + D;
        drive(1'b0, 1'b1, 1'b1, 8'hFF); // unchanged pair: nothing stored (R2)
        drive(1'b0, 1'b1, 1'b1, 8'hEE);
        drive(1'b1, 1'b1, 1'b1, 8'h00);
        expect_ev(2, 3, nedge, "R6"); exp_irq = nedge + D;
        settle();
        check(dev_req_n == 1'b1, "R7", int'(dev_req_n), 1);
        wait_irq();
        pkt_sel = 4'd0; #1 check(pkt_byte == 8'hA1, "R2", int'(pkt_byte), 'hA1);
        pkt_sel = 4'd1; #1 check(pkt_byte == 8'hB2, "R2", int'(pkt_byte), 'hB2);
        pkt_sel = 4'd2; #1 check(pkt_byte == 8'hC3, "R2", int'(pkt_byte), 'hC3);

        // Scenario B: 18 bytes offered, only 16 kept (R3)
        drive(1'b0, 1'b1, 1'b1, 8'h10); exp_irq = nedge + D;
        for (int i = 1; i < 18; i++) begin
            drive(1'b0, (i % 2 == 1) ? 1'b0 : 1'b1, 1'b1, 8'(8'h10 + i));
            if (i < 16) exp_irq = nedge + D;
        end
        drive(1'b1, 1'b0, 1'b1, 8'h00);
        expect_ev(2, 16, nedge, "R3"); exp_irq = nedge + D;
        wait_irq();
        pkt_sel = 4'd15; #1 check(pkt_byte == 8'h1F, "R3", int'(pkt_byte), 'h1F);
        pkt_sel = 4'd0;  #1 check(pkt_byte == 8'h10, "R2", int'(pkt_byte), 'h10);

        // Scenario C: three-byte reply (R10, R8, R4, R5, R11, R7)
        write_reply(0, 8'h5A);
        write_reply(1, 8'h6B);
        write_reply(2, 8'h7C);
        start_reply(3);
        check(dev_req_n == 1'b1, "R10", int'(dev_req_n), 1);
        wait_irq();
        drive(1'b1, 1'b1, 1'b0, 8'h00);          // resync with reply pending
        expect_ev(0, 0, nedge, "R8"); exp_irq = nedge + D;
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        expect_ev(1, 'h5A, nedge, "R4"); exp_irq = nedge + D;
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        expect_ev(1, 'h6B, nedge, "R4"); exp_irq = nedge + D;
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        expect_ev(0, 1, nedge, "R5");
        expect_ev(1, 'h7C, nedge, "R4"); exp_irq = nedge + D;
        drive(1'b0, 1'b0, 1'b0, 8'h00);          // no reply left: no effect
        settle();
        check(dev_byte == 8'h7C, "R11", int'(dev_byte), 'h7C);
        drive(1'b1, 1'b0, 1'b0, 8'h00);          // end of transfer, nothing pending
        exp_irq = nedge + D;
        settle();
        check(dev_req_n == 1'b1, "R7", int'(dev_req_n), 1);
        wait_irq();

        // Scenario D: transfer ends with a byte still pending (R7, R8)
        write_reply(0, 8'h11);
        write_reply(1, 8'h22);
        start_reply(2);
        wait_irq();
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        expect_ev(1, 'h11, nedge, "R4"); exp_irq = nedge + D;
        drive(1'b1, 1'b1, 1'b0, 8'h00);
        expect_ev(0, 0, nedge, "R7"); exp_irq = nedge + D;
        drive(1'b1, 1'b0, 1'b0, 8'h00);          // resync, still pending
        exp_irq = nedge + D;
        settle();
        check(dev_req_n == 1'b0, "R8", int'(dev_req_n), 0);
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        expect_ev(0, 1, nedge, "R5");
        expect_ev(1, 'h22, nedge, "R4"); exp_irq = nedge + D;
        drive(1'b1, 1'b1, 1'b0, 8'h00);
        exp_irq = nedge + D;
        drive(1'b1, 1'b0, 1'b0, 8'h00);          // resync, nothing pending
        exp_irq = nedge + D;
        settle();
        check(dev_req_n == 1'b1, "R8", int'(dev_req_n), 1);
        wait_irq();

        // Scenario E: delay restart (R9) and read index restart (R10)
        start_reply(0);
        repeat (10) @(negedge clk);
        start_reply(2);                           // earlier pulse must not appear
        wait_irq();
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        expect_ev(1, 'h11, nedge, "R10"); exp_irq = nedge + D;
        drive(1'b1, 1'b1, 1'b0, 8'h00);
        expect_ev(0, 0, nedge, "R7"); exp_irq = nedge + D;
        wait_irq();

        check(exp_q.size() == 0, "R4", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule